// File: doc/BRIEF.md
# Delta-Correlation Stream Prefetcher

This block watches a stream of cache-miss events. Each event carries the address of the instruction that made the access and the data address it touched. For every instruction it learns a short history of address deltas, and it uses that history to guess where the next miss will land. A direct-mapped per-instruction table holds four items: a tag, the low half of the last address, a hashed delta history and a two-bit confidence counter. A delta table shared by all instructions maps a hashed history to the delta that last followed it. The hash folds each new delta into the shifted old history.

A training event updates both tables in one cycle. When the instruction's confidence is high enough, the event also yields a candidate address. A chaining engine then keeps walking the delta table without further input. It emits one more candidate per idle cycle until the requested degree is used up. The block only proposes addresses. Deciding whether to issue them, and filtering them against outstanding requests, happens outside.

Top module: `dcp_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low. Every history-table field and every delta-table entry reads as zero.
- R2: The history entry is selected by `trig_pc[7:0]`, and its tag is `trig_pc[23:8]`. PC bits above bit 23 play no part. When an event's tag differs from the stored tag, the entry is rewritten with the new tag, history 0, confidence 0 and last address `trig_addr[15:0]`. No candidate follows, the delta table is left alone, and the chaining engine holds its state for that cycle.
- R3: On a tag match, the actual delta is `(trig_addr[15:0] - last)` modulo 2^16. Confidence rises by one, saturating at 3, when this delta equals the delta-table entry at the old history. Otherwise it falls by one, saturating at 0.
- R4: The new history is `((old << 5) mod 256)` XOR the fold of the 16-bit delta, where the fold is its two 8-bit halves XORed together.
- R5: On a tag match, the delta-table entry at the old history takes the actual delta. The history entry takes the new last address, the new history and the new confidence.
- R6: On a tag match with new confidence of 2 or more and a non-zero degree, the block forms the candidate `trig_addr` plus the sign-extended delta-table entry at the new history. That lookup sees this event's own update. `pf_valid`/`pf_addr` show the candidate on the cycle after the event.
- R7: A candidate equal to the address it was derived from is never raised on `pf_valid`. For an event this is `trig_addr`; for a chained step it is the engine's current address.
- R8: With `degree` equal to 0, a matching event still updates both tables. It raises no candidate and does not reload the chaining engine.
- R9: Every candidate formed under R6 loads the chaining engine, whether or not R7 suppresses it. The engine gets the new history, `trig_addr[15:0]` as its last address, the candidate as its address, and `degree - 1` steps.
- R10: In a cycle with no event, an engine with steps left and a non-zero history does four things. It takes the delta from its address minus its last address, rehashes its history per R4, and predicts its address plus the sign-extended delta-table entry at that history. It then moves last to the old address, address to the prediction, and decrements the step count. The output follows on the next cycle under R7.
- R11: Events take priority over the engine in the same cycle. The engine is idle when its step count or its history is zero. At most one candidate appears per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | A training event (demand miss or first use of a prefetched line) is present |
| trig_pc | input | 32 | Instruction address of the event |
| trig_addr | input | 32 | Data address of the event |
| degree | input | 4 | Number of candidates allowed per confident event, 0 disables emission |
| pf_valid | output | 1 | A candidate address is presented |
| pf_addr | output | 32 | Candidate prefetch address |

## Verification
The bench goes after four corner cases.

- Aliasing instructions that share an index but carry different tags, and PCs that differ only above the tag. A design that decoded the wrong PC bits would mistrain or reallocate on the wrong events.
- Streams whose new history equals their old history. A design without write forwarding would predict from a stale delta and drift by one stride.
- A zero-delta stream. This checks that a self-address candidate is silenced, and that a history which decays to zero halts the chain. A faulty design would emit redundant candidates or keep chaining forever.
- A zero degree and events that interrupt a running chain. A design that got these wrong would emit when told not to, reload the engine, or let the engine step during an event.

Negative strides check that deltas are sign-extended onto the full address.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    // Confidence counter geometry and thresholds
    localparam int              CONF_W    = 2;
    localparam logic [CONF_W-1:0] CONF_MAX  = 2'd3;
    localparam logic [CONF_W-1:0] CONF_FIRE = 2'd2;

    // What the datapath does in a given cycle
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_ALLOC = 2'd1,
        ACT_TRAIN = 2'd2,
        ACT_CHAIN = 2'd3
    } act_e;

endpackage

// File: rtl/dcp_hist_hash.sv
// Folds a delta into chunks of HIST_W bits and mixes it with the shifted history.
module dcp_hist_hash #(
    parameter int DELTA_W    = 16,
    parameter int HIST_W     = 8,
    parameter int HIST_SHIFT = 5
) (
    input  logic [HIST_W-1:0]  hist_in,
    input  logic [DELTA_W-1:0] delta,
    output logic [HIST_W-1:0]  hist_out
);
    localparam int CHUNKS = (DELTA_W + HIST_W - 1) / HIST_W;
    localparam int PAD_W  = CHUNKS * HIST_W;

    logic [PAD_W-1:0]  padded;
    logic [HIST_W-1:0] fold [CHUNKS+1];
    logic [HIST_W-1:0] shifted;

    assign padded  = PAD_W'(delta);
    assign fold[0] = '0;

    for (genvar c = 0; c < CHUNKS; c++) begin : g_fold
        assign fold[c+1] = fold[c] ^ padded[c*HIST_W +: HIST_W];
    end

    assign shifted  = hist_in << HIST_SHIFT;
    assign hist_out = shifted ^ fold[CHUNKS];

endmodule

// File: rtl/dcp_hist_table.sv
// Direct-mapped per-instruction table: one asynchronous read, one write.
module dcp_hist_table #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dcp_delta_table.sv
// Shared delta table: NRD asynchronous read ports, one write port.
module dcp_delta_table #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16,
    parameter int NRD    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_idx[p]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dcp_prefetcher.sv
module dcp_prefetcher #(
    parameter int ADDR_W     = 32,
    parameter int HT_BITS    = 8,
    parameter int TAG_W      = 16,
    parameter int DELTA_W    = 16,
    parameter int DT_BITS    = 8,
    parameter int HIST_SHIFT = 5,
    parameter int DEG_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [ADDR_W-1:0] trig_pc,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [DEG_W-1:0]  degree,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    import dcp_pkg::*;

    localparam int HT_ENTRY_W = TAG_W + DELTA_W + DT_BITS + CONF_W;
    localparam int EXT_W      = ADDR_W - DELTA_W;
    localparam int N_DT_RD    = 3;
    localparam int RD_OLD     = 0;
    localparam int RD_NEW     = 1;
    localparam int RD_CHN     = 2;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [DELTA_W-1:0] last;
        logic [DT_BITS-1:0] hist;
        logic [CONF_W-1:0]  conf;
    } ht_entry_t;

    typedef struct packed {
        logic               pf_valid;
        logic [ADDR_W-1:0]  pf_addr;
        logic [DT_BITS-1:0] ch_hist;
        logic [DELTA_W-1:0] ch_last;
        logic [ADDR_W-1:0]  ch_addr;
        logic [DEG_W-1:0]   ch_deg;
    } state_t;

    function automatic logic [ADDR_W-1:0] sext(input logic [DELTA_W-1:0] d);
        return {{EXT_W{d[DELTA_W-1]}}, d};
    endfunction

    state_t state_d, state_q;
    act_e   act;

    // history table wiring
    logic [HT_BITS-1:0]    trig_idx;
    logic [TAG_W-1:0]      trig_tag;
    logic [HT_ENTRY_W-1:0] ht_rd_raw;
    ht_entry_t             ht_rd;
    ht_entry_t             ht_wr;
    logic                  ht_we;

    // delta table wiring
    logic [N_DT_RD-1:0][DT_BITS-1:0] dt_rd_idx;
    logic [N_DT_RD-1:0][DELTA_W-1:0] dt_rd_data;
    logic                            dt_we;
    logic [DT_BITS-1:0]              dt_wr_idx;
    logic [DELTA_W-1:0]              dt_wr_data;

    // training path
    logic               tag_hit;
    logic [DELTA_W-1:0] act_delta;
    logic [DT_BITS-1:0] trn_hist;
    logic [DELTA_W-1:0] trn_next_delta;
    logic [CONF_W-1:0]  trn_conf;
    logic [ADDR_W-1:0]  trn_pred;

    // chaining path
    logic [DELTA_W-1:0] ch_delta;
    logic [DT_BITS-1:0] ch_hist_n;
    logic [ADDR_W-1:0]  ch_pred;

    // names observed by the bound checker
    logic [DEG_W-1:0]   chain_deg;
    logic [DT_BITS-1:0] chain_hist;
    logic [ADDR_W-1:0]  chain_addr;

    assign trig_idx = trig_pc[HT_BITS-1:0];
    assign trig_tag = trig_pc[HT_BITS +: TAG_W];

    if (ADDR_W > HT_BITS + TAG_W) begin : g_pc_hi
        logic unused_pc_hi;
        assign unused_pc_hi = ^trig_pc[ADDR_W-1:HT_BITS+TAG_W];
    end

    dcp_hist_table #(
        .IDX_W   (HT_BITS),
        .ENTRY_W (HT_ENTRY_W)
    ) ht_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (trig_idx),
        .rd_data (ht_rd_raw),
        .wr_en   (ht_we),
        .wr_idx  (trig_idx),
        .wr_data (ht_wr)
    );

    assign ht_rd = ht_entry_t'(ht_rd_raw);

    dcp_delta_table #(
        .IDX_W  (DT_BITS),
        .DATA_W (DELTA_W),
        .NRD    (N_DT_RD)
    ) dt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (dt_rd_idx),
        .rd_data (dt_rd_data),
        .wr_en   (dt_we),
        .wr_idx  (dt_wr_idx),
        .wr_data (dt_wr_data)
    );

    // Training: delta, rehash, forwarded lookup at the new history
    assign tag_hit   = (ht_rd.tag == trig_tag);
    assign act_delta = trig_addr[DELTA_W-1:0] - ht_rd.last;

    dcp_hist_hash #(
        .DELTA_W    (DELTA_W),
        .HIST_W     (DT_BITS),
        .HIST_SHIFT (HIST_SHIFT)
    ) trn_hash_i (
        .hist_in  (ht_rd.hist),
        .delta    (act_delta),
        .hist_out (trn_hist)
    );

    // Chaining: delta between the engine's address and its last address
    assign ch_delta = state_q.ch_addr[DELTA_W-1:0] - state_q.ch_last;

    dcp_hist_hash #(
        .DELTA_W    (DELTA_W),
        .HIST_W     (DT_BITS),
        .HIST_SHIFT (HIST_SHIFT)
    ) chn_hash_i (
        .hist_in  (state_q.ch_hist),
        .delta    (ch_delta),
        .hist_out (ch_hist_n)
    );

    always_comb begin
        dt_rd_idx         = '0;
        dt_rd_idx[RD_OLD] = ht_rd.hist;
        dt_rd_idx[RD_NEW] = trn_hist;
        dt_rd_idx[RD_CHN] = ch_hist_n;
    end

    // the write at the old history must be visible to the lookup at the new one
    assign trn_next_delta = (trn_hist == ht_rd.hist) ? act_delta : dt_rd_data[RD_NEW];
    assign trn_pred       = trig_addr + sext(trn_next_delta);
    assign ch_pred        = state_q.ch_addr + sext(dt_rd_data[RD_CHN]);

    always_comb begin
        if (act_delta == dt_rd_data[RD_OLD]) begin
            trn_conf = (ht_rd.conf == CONF_MAX) ? CONF_MAX : ht_rd.conf + 2'd1;
        end else begin
            trn_conf = (ht_rd.conf == '0) ? '0 : ht_rd.conf - 2'd1;
        end
    end

    always_comb begin
        if (trig_valid) begin
            act = tag_hit ? ACT_TRAIN : ACT_ALLOC;
        end else if (state_q.ch_deg != '0 && state_q.ch_hist != '0) begin
            act = ACT_CHAIN;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_comb begin
        state_d          = state_q;
        state_d.pf_valid = 1'b0;
        ht_we            = 1'b0;
        ht_wr            = ht_rd;
        dt_we            = 1'b0;
        dt_wr_idx        = ht_rd.hist;
        dt_wr_data       = act_delta;

        case (act)
            ACT_ALLOC: begin
                ht_we      = 1'b1;
                ht_wr.tag  = trig_tag;
                ht_wr.last = trig_addr[DELTA_W-1:0];
                ht_wr.hist = '0;
                ht_wr.conf = '0;
            end
            ACT_TRAIN: begin
                ht_we      = 1'b1;
                dt_we      = 1'b1;
                ht_wr.last = trig_addr[DELTA_W-1:0];
                ht_wr.hist = trn_hist;
                ht_wr.conf = trn_conf;
                if (trn_conf >= CONF_FIRE && degree != '0) begin
                    state_d.pf_valid = (trn_pred != trig_addr);
                    state_d.pf_addr  = trn_pred;
                    state_d.ch_hist  = trn_hist;
                    state_d.ch_last  = trig_addr[DELTA_W-1:0];
                    state_d.ch_addr  = trn_pred;
                    state_d.ch_deg   = degree - DEG_W'(1);
                end
            end
            ACT_CHAIN: begin
                state_d.pf_valid = (ch_pred != state_q.ch_addr);
                state_d.pf_addr  = ch_pred;
                state_d.ch_hist  = ch_hist_n;
                state_d.ch_last  = state_q.ch_addr[DELTA_W-1:0];
                state_d.ch_addr  = ch_pred;
                state_d.ch_deg   = state_q.ch_deg - DEG_W'(1);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pf_valid   = state_q.pf_valid;
    assign pf_addr    = state_q.pf_addr;
    assign chain_deg  = state_q.ch_deg;
    assign chain_hist = state_q.ch_hist;
    assign chain_addr = state_q.ch_addr;

endmodule

// File: rtl/dcp_prefetcher_chk.sv
module dcp_prefetcher_chk #(
    parameter int ADDR_W  = 32,
    parameter int DT_BITS = 8,
    parameter int DEG_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_valid,
    input logic [DEG_W-1:0]   degree,
    input logic               tag_hit,
    input logic [DEG_W-1:0]   chain_deg,
    input logic [DT_BITS-1:0] chain_hist,
    input logic [ADDR_W-1:0]  chain_addr,
    input logic               pf_valid,
    input logic [ADDR_W-1:0]  pf_addr
);

    // R1: first cycle out of reset shows no candidate
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pf_valid);

    // R2: a reallocating event yields nothing and freezes the engine
    a_r2_alloc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !tag_hit) |=> (!pf_valid && $stable(chain_deg) && $stable(chain_addr)));

    // R8: zero degree never emits from an event
    a_r8_zero_degree: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && degree == '0) |=> !pf_valid);

    // R7: a chained candidate never repeats the address it came from
    a_r7_no_self_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && chain_deg != '0 && chain_hist != '0) |=>
            !(pf_valid && pf_addr == $past(chain_addr)));

    // R10: each chained step consumes exactly one unit of degree
    a_r10_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && chain_deg != '0 && chain_hist != '0) |=>
            (chain_deg == $past(chain_deg) - 1'b1));

    // R11: an idle engine with no event produces nothing and keeps its state
    a_r11_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && (chain_deg == '0 || chain_hist == '0)) |=>
            (!pf_valid && $stable(chain_deg)));

endmodule

bind dcp_prefetcher dcp_prefetcher_chk #(
    .ADDR_W  (ADDR_W),
    .DT_BITS (DT_BITS),
    .DEG_W   (DEG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .degree     (degree),
    .tag_hit    (tag_hit),
    .chain_deg  (chain_deg),
    .chain_hist (chain_hist),
    .chain_addr (chain_addr),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
);

// File: tb/dcp_prefetcher_tb.sv
module dcp_prefetcher_tb_top;

    localparam int AW = 32;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_valid = 1'b0;
    logic [AW-1:0] trig_pc = '0;
    logic [AW-1:0] trig_addr = '0;
    logic [DW-1:0] degree = '0;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk; // 250 MHz

    dcp_prefetcher dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_pc    (trig_pc),
        .trig_addr  (trig_addr),
        .degree     (degree),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [15:0] m_tag  [256];
    logic [15:0] m_last [256];
    logic [7:0]  m_hist [256];
    logic [1:0]  m_conf [256];
    logic [15:0] m_dt   [256];
    logic [7:0]  c_hist;
    logic [15:0] c_last;
    logic [31:0] c_addr;
    logic [3:0]  c_deg;

    function automatic logic [7:0] m_hash(logic [7:0] h, logic [15:0] d);
        logic [15:0] s = d;
        logic [7:0]  f = 8'h00;
        logic [7:0]  sh;
        while (s != 16'h0) begin
            f = f ^ s[7:0];
            s = s >> 8;
        end
        sh = h << 5;
        return sh ^ f;
    endfunction

    function automatic logic [31:0] m_sx(logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_tag[i] = '0; m_last[i] = '0; m_hist[i] = '0; m_conf[i] = '0; m_dt[i] = '0;
        end
        c_hist = '0; c_last = '0; c_addr = '0; c_deg = '0;
    endtask

    // Advance the model by one cycle; returns expected output and a requirement tag
    task automatic model_step(input logic v, input logic [31:0] pc, input logic [31:0] a,
                              input logic [3:0] dg, output logic ev, output logic [31:0] ea,
                              output string req);
        logic [7:0]  ix;
        logic [15:0] tg, dl;
        logic [7:0]  oh, nh;
        logic [1:0]  cf;
        logic [31:0] p;
        ev = 1'b0; ea = '0; req = "R11";
        if (v) begin
            ix = pc[7:0];
            tg = pc[23:8];
            if (m_tag[ix] != tg) begin
                m_tag[ix] = tg; m_hist[ix] = '0; m_conf[ix] = '0; m_last[ix] = a[15:0];
                req = "R2";
            end else begin
                oh = m_hist[ix];
                dl = a[15:0] - m_last[ix];
                cf = m_conf[ix];
                if (dl == m_dt[oh]) begin if (cf != 2'd3) cf = cf + 2'd1; end
                else begin if (cf != 2'd0) cf = cf - 2'd1; end
                nh = m_hash(oh, dl);
                m_dt[oh] = dl;
                m_last[ix] = a[15:0]; m_hist[ix] = nh; m_conf[ix] = cf;
                req = "R3";
                if (dg == 4'd0) req = "R8";
                else if (cf >= 2'd2) begin
                    p = a + m_sx(m_dt[nh]);
                    ev = (p != a); ea = p;
                    req = ev ? "R6" : "R7";
                    c_hist = nh; c_last = a[15:0]; c_addr = p; c_deg = dg - 4'd1;
                end
            end
        end else if (c_deg != 4'd0 && c_hist != 8'd0) begin
            dl = c_addr[15:0] - c_last;
            c_hist = m_hash(c_hist, dl);
            p = c_addr + m_sx(m_dt[c_hist]);
            ev = (p != c_addr); ea = p;
            req = ev ? "R10" : "R7";
            c_last = c_addr[15:0]; c_addr = p; c_deg = c_deg - 4'd1;
        end
    endtask

    task automatic check(input string req, input logic ev, input logic [31:0] ea);
        n_checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b addr=%08h, expected valid=%0b addr=%08h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // Drive one cycle at a falling edge, then compare at the next falling edge
    task automatic cyc(input logic v, input logic [31:0] pc, input logic [31:0] a,
                       input logic [3:0] dg);
        logic ev; logic [31:0] ea; string req;
        trig_valid = v; trig_pc = pc; trig_addr = a; degree = dg;
        model_step(v, pc, a, dg, ev, ea, req);
        @(negedge clk);
        check(req, ev, ea);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 4'd3);
    endtask

    task automatic stream(input logic [31:0] pc, input logic [31:0] base, input int stride,
                          input int n, input logic [3:0] dg, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, pc, base + 32'(i * stride), dg);
            idle(gap);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [31:0] pc_pool [8];
    logic [31:0] nxt_addr [8];
    int          strd [8];

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: quiet during and right after reset
        check("R1", 1'b0, '0);
        rst_n = 1'b1;
        idle(2);

        // R6/R9/R10: forward stride under PC with zero tag, chain drains in idle cycles
        stream(32'h0000_0040, 32'h0001_0000, 64, 6, 4'd4, 0);
        idle(5);
        // R6: negative stride exercises sign extension
        stream(32'h0000_0041, 32'h0003_0000, -128, 6, 4'd3, 3);
        // R11: events interrupting a running chain
        stream(32'h0000_0040, 32'h0001_0180, 64, 4, 4'd6, 1);
        idle(6);
        // R8: zero degree trains silently
        stream(32'h0000_0042, 32'h0005_0000, 256, 6, 4'd0, 1);
        // R2: alias at same index with a different tag, then the original again
        stream(32'h0001_2342, 32'h0007_0000, 64, 3, 4'd2, 0);
        stream(32'h0000_0042, 32'h0005_0600, 256, 3, 4'd2, 2);
        // R2: bits above the tag are ignored
        stream(32'hFF00_0042, 32'h0005_0900, 256, 3, 4'd2, 2);
        // R7: zero-delta stream suppresses self-addressed candidates; chain halts on zero history
        stream(32'h0000_0055, 32'h0009_1000, 0, 8, 4'd5, 2);
        idle(4);
        // R4/R5: delta whose fold aliases histories; degree one means no chaining
        stream(32'h0000_0066, 32'h000A_0000, 32'h0101, 6, 4'd1, 1);

        // constrained random mix
        pc_pool[0] = 32'h0000_0100; pc_pool[1] = 32'h0001_0100;
        pc_pool[2] = 32'h0000_0204; pc_pool[3] = 32'hAB00_0204;
        pc_pool[4] = 32'h0000_0337; pc_pool[5] = 32'h0002_0204;
        pc_pool[6] = 32'h0000_04C0; pc_pool[7] = 32'h0000_0040;
        for (int k = 0; k < 8; k++) begin
            nxt_addr[k] = 32'h0010_0000 * (k + 1);
            strd[k] = 64 * (k % 3 + 1);
        end
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic [3:0] dg;
            k = int'($urandom_range(7, 0));
            dg = ($urandom_range(5, 0) == 0) ? 4'd0 : 4'($urandom_range(5, 1));
            if ($urandom_range(1, 0) == 1) begin
                if ($urandom_range(15, 0) == 0) begin
                    case ($urandom_range(4, 0))
                        0: strd[k] = 64;
                        1: strd[k] = -64;
                        2: strd[k] = 192;
                        3: strd[k] = 0;
                        default: strd[k] = 4160;
                    endcase
                end
                if ($urandom_range(31, 0) == 0) nxt_addr[k] = $urandom();
                cyc(1'b1, pc_pool[k], nxt_addr[k], dg);
                nxt_addr[k] = nxt_addr[k] + 32'(strd[k]);
            end else begin
                cyc(1'b0, '0, '0, dg);
            end
        end
        idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule